// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous request stream and an asynchronous static RAM with a 19-bit word address and a 16-bit data bus made of two byte lanes. A request carries a write flag, an address, write data and one enable bit per byte lane. The block accepts it with a valid/ready handshake and plays out the strobe sequence the RAM needs. Every interval is a whole number of clock cycles, derived from nanosecond limits and a clock-period parameter.

The RAM side has a low-active select and a high-active select, a low-active write strobe and a low-active output enable. It also has a low-active strobe per byte lane, the address, and a split data bus: an output, its drive enable and an input. The tristate buffer sits at the pad. Read results come back as a one-cycle pulse with no back-pressure.

Back-pressure rules: a request transfers on a rising edge where `req_valid` and `req_ready` are both high. The requester holds its fields stable while `req_valid` is high and `req_ready` is low. `req_ready` stays low from the cycle after acceptance until the operation's cycle time has elapsed. `rsp_valid` cannot be stalled, so the requester must take the data in that cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, the RAM is idle. The select pins read `mem_ce_n`=1 and `mem_ce`=0, with `mem_we_n`=1, `mem_oe_n`=1, `mem_bs_n`=2'b11 and `mem_dq_oe`=0.
- R2: A request is taken on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low in every following cycle until the operation finishes, and a request held valid meanwhile is taken only after `req_ready` returns high.
- R3: A write holds the RAM selected with `mem_we_n` low and `mem_oe_n` high for WP cycles. Lane strobe `mem_bs_n[i]` is low exactly when enable `req_be[i]` is 1, where bit 0 is the lower lane (data 7:0) and bit 1 is the upper lane (data 15:8). The address and write data are driven with `mem_dq_oe` high.
- R4: After the write strobe rises, the RAM is deselected while the write data stays driven for REC = max(WC-WP,1) cycles. The write and output-enable strobes are never low together.
- R5: A read holds the RAM selected with `mem_oe_n` low, `mem_we_n` high and `mem_dq_oe` low for RD cycles, with lane strobes as in R3.
- R6: The bus is sampled on the last read cycle. In the next cycle `rsp_valid` is high for exactly one cycle, and `req_ready` rises in that same cycle. Lanes that were not enabled read as zero.
- R7: After a read's output enable rises, `mem_dq_oe` stays low for at least TA = ceil(30 ns / CLK_NS) cycles. A write accepted earlier waits with every strobe inactive and `req_ready` low.
- R8: A request with both enable bits 0 drives no strobe, produces no `rsp_valid` and leaves the memory unchanged. `req_ready` is low for exactly one cycle after it is taken.
- R9: A write changes only the enabled lanes; the other lane keeps its earlier contents.
- R10: Intervals are ceil(ns / CLK_NS) and stretch write data setup into the pulse. WP = max(ceil(50/CLK), ceil(30/CLK)), WC = ceil(70/CLK), RD = max(ceil(70/CLK), ceil(70/CLK)). At CLK_NS = 5 this gives WP = 10, a 14-cycle write, RD = 14 and TA = 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 lower lane, bit 1 upper lane |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_data | output | 16 | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | Low-active chip select |
| mem_ce | output | 1 | High-active chip select |
| mem_we_n | output | 1 | Low-active write strobe |
| mem_oe_n | output | 1 | Low-active output enable |
| mem_bs_n | output | 2 | Low-active lane strobes, bit 0 lower lane |
| mem_addr | output | 19 | RAM address |
| mem_dq_out | output | 16 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data from the RAM |

## Verification
The read completion pulse and the acceptance of the next request fall in the same cycle. That cycle may also start the turnaround wait when the next request is a write. The bench provokes this by holding the next request valid while a read is in flight, so that it is taken on the very edge after `rsp_valid` rises. A reference timeline in the bench then predicts every pin in every following cycle. It judges the response data, the one-cycle ready gap and the delayed data drive against that timeline.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_NOP,
    PH_GAP,
    PH_WR,
    PH_REC,
    PH_RD
  } phase_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int WP_CYC  = 5,
  parameter int REC_CYC = 2,
  parameter int RD_CYC  = 7,
  parameter int TA_CYC  = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  input  logic   be_any,
  output logic   req_ready,
  output logic   accept,
  output phase_e phase_d,
  output logic   capture
);

  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LD  = CNT_W'(TA_CYC - 1);

  phase_e           phase_q;
  logic             cyc_load;
  logic [CNT_W-1:0] cyc_val;
  logic             cyc_zero;
  logic             ta_load;
  logic             ta_zero;

  // interval counter for the current phase
  sram_lane_timer #(.CNT_W(CNT_W)) u_cyc_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cyc_load),
    .load_val (cyc_val),
    .zero     (cyc_zero)
  );

  // bus turnaround counter, started when a read releases the bus
  sram_lane_timer #(.CNT_W(CNT_W)) u_ta_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ta_load),
    .load_val (TA_LD),
    .zero     (ta_zero)
  );

  assign req_ready = (phase_q == PH_IDLE);

  always_comb begin
    phase_d  = phase_q;
    accept   = 1'b0;
    capture  = 1'b0;
    cyc_load = 1'b0;
    cyc_val  = '0;
    ta_load  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (!be_any) begin
            phase_d = PH_NOP;
          end else if (req_write) begin
            if (ta_zero) begin
              phase_d  = PH_WR;
              cyc_load = 1'b1;
              cyc_val  = WP_LD;
            end else begin
              phase_d = PH_GAP;
            end
          end else begin
            phase_d  = PH_RD;
            cyc_load = 1'b1;
            cyc_val  = RD_LD;
          end
        end
      end
      PH_NOP: phase_d = PH_IDLE;
      PH_GAP: begin
        if (ta_zero) begin
          phase_d  = PH_WR;
          cyc_load = 1'b1;
          cyc_val  = WP_LD;
        end
      end
      PH_WR: begin
        if (cyc_zero) begin
          phase_d  = PH_REC;
          cyc_load = 1'b1;
          cyc_val  = REC_LD;
        end
      end
      PH_REC: begin
        if (cyc_zero) phase_d = PH_IDLE;
      end
      PH_RD: begin
        if (cyc_zero) begin
          phase_d = PH_IDLE;
          capture = 1'b1;
          ta_load = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/sram_lane_pins.sv
module sram_lane_pins
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  phase_e            phase_d,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_bs_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  localparam int LANE_W = DATA_W / LANES;

  logic [LANES-1:0]  be_q;
  logic [LANES-1:0]  be_eff;
  logic [LANES-1:0]  bs_n_d;
  logic [DATA_W-1:0] cap_d;
  logic              sel_d;

  assign be_eff = accept ? req_be : be_q;
  assign sel_d  = (phase_d == PH_WR) || (phase_d == PH_RD);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign bs_n_d[i] = ~(sel_d & be_eff[i]);
    assign cap_d[i*LANE_W +: LANE_W] =
      be_q[i] ? mem_dq_in[i*LANE_W +: LANE_W] : '0;
  end

  // request fields held for the whole operation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q       <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      be_q       <= req_be;
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  // strobes registered from the next phase so they never glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_ce    <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_bs_n  <= '1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_ce_n  <= ~sel_d;
      mem_ce    <= sel_d;
      mem_we_n  <= ~(phase_d == PH_WR);
      mem_oe_n  <= ~(phase_d == PH_RD);
      mem_bs_n  <= bs_n_d;
      mem_dq_oe <= (phase_d == PH_WR) || (phase_d == PH_REC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_data <= cap_d;
    end
  end

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R4
  AST_DRIVE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R7
  AST_STROBE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(&mem_bs_n) |-> (!mem_ce_n && mem_ce)); // R3
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter int LANES    = 2,
  parameter int CLK_NS   = 10,
  parameter int T_WP_NS  = 50,
  parameter int T_DW_NS  = 30,
  parameter int T_WC_NS  = 70,
  parameter int T_ACC_NS = 70,
  parameter int T_RC_NS  = 70,
  parameter int T_HZ_NS  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_bs_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  // R10: every limit rounded up to whole cycles
  localparam int WP_CYC  = imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS));
  localparam int REC_CYC = imax(ns_to_cyc(T_WC_NS, CLK_NS) - WP_CYC, 1);
  localparam int RD_CYC  = imax(ns_to_cyc(T_ACC_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int TA_CYC  = imax(ns_to_cyc(T_HZ_NS, CLK_NS), 1);
  localparam int CNT_MAX = imax(imax(WP_CYC, REC_CYC), imax(RD_CYC, TA_CYC));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int SR_W    = $clog2(TA_CYC + 1);
  localparam logic [SR_W-1:0] TA_V = SR_W'(TA_CYC);

  logic   accept;
  logic   capture;
  phase_e phase_d;

  sram_lane_fsm #(
    .CNT_W   (CNT_W),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC),
    .RD_CYC  (RD_CYC),
    .TA_CYC  (TA_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .be_any    (|req_be),
    .req_ready (req_ready),
    .accept    (accept),
    .phase_d   (phase_d),
    .capture   (capture)
  );

  sram_lane_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .phase_d    (phase_d),
    .capture    (capture),
    .mem_dq_in  (mem_dq_in),
    .mem_ce_n   (mem_ce_n),
    .mem_ce     (mem_ce),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_bs_n   (mem_bs_n),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

  // cycles since the output enable was last low, saturating at TA
  logic [SR_W-1:0] since_rd_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             since_rd_q <= TA_V;
    else if (!mem_oe_n)     since_rd_q <= '0;
    else if (since_rd_q != TA_V) since_rd_q <= since_rd_q + 1'b1;
  end

  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (since_rd_q >= TA_V)); // R7
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && (&mem_bs_n))); // R1

endmodule

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb;

  // expected intervals at a 5 ns clock, worked out from the limits
  localparam int WP  = 10;  // ceil(50/5)
  localparam int REC = 4;   // ceil(70/5) - 10
  localparam int RD  = 14;  // ceil(70/5)
  localparam int TA  = 6;   // ceil(30/5)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_bs_n;
  logic [18:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = '0;

  always #2.5 clk = ~clk;

  sram_lane_ctrl #(.CLK_NS(5)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_bs_n(mem_bs_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference timeline ----------------
  logic [15:0] exp_mem [int];
  logic [15:0] ram [int];
  int cyc = 0, busy_end = 0, rd_end = -1000;
  int op_kind = 0, op_a = 0, op_s = 0;   // kind: 0 none, 1 write, 2 read, 3 no-op
  logic [18:0] op_addr;
  logic [15:0] op_wdata, exp_rdata;
  logic [1:0]  op_be;

  function automatic logic [15:0] rd_word(input logic [15:0] m [int], input int k);
    return m.exists(k) ? m[k] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; busy_end = 0; rd_end = -1000; op_kind = 0;
    end else begin
      if (cyc >= busy_end && req_valid) begin
        op_a = cyc + 1; op_addr = req_addr; op_wdata = req_wdata; op_be = req_be;
        if (req_be == 2'b00) begin
          op_kind = 3; busy_end = op_a + 1;
        end else if (req_write) begin
          logic [15:0] w;
          op_kind = 1;
          op_s = (op_a > rd_end + TA) ? op_a : rd_end + TA;
          busy_end = op_s + WP + REC;
          w = rd_word(exp_mem, int'(req_addr));
          if (req_be[0]) w[7:0]  = req_wdata[7:0];
          if (req_be[1]) w[15:8] = req_wdata[15:8];
          exp_mem[int'(req_addr)] = w;
        end else begin
          logic [15:0] r;
          op_kind = 2;
          busy_end = op_a + RD; rd_end = op_a + RD;
          r = rd_word(exp_mem, int'(req_addr));
          exp_rdata = {req_be[1] ? r[15:8] : 8'h00, req_be[0] ? r[7:0] : 8'h00};
        end
      end
      cyc = cyc + 1;
    end
  end

  // ---------------- per-cycle compare and RAM model ----------------
  int we_run = 0, oe_run = 0, oe_rise_t = -1000;
  logic prev_dq_oe = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      int t;
      logic [6:0] ep, ap;
      string tag;
      logic sel, ersp;
      t = cyc;
      ep = 7'b1011110; tag = "R1"; sel = 1'b0; ersp = 1'b0;
      if (op_kind == 1) begin
        if (t >= op_a && t < op_s) tag = "R7";
        if (t >= op_s && t < op_s + WP) begin
          ep = {1'b0, 1'b1, 1'b0, 1'b1, ~op_be, 1'b1}; tag = "R3"; sel = 1'b1;
        end else if (t >= op_s + WP && t < busy_end) begin
          ep = 7'b1011111; tag = "R4";
        end
      end else if (op_kind == 2) begin
        if (t >= op_a && t < op_a + RD) begin
          ep = {1'b0, 1'b1, 1'b1, 1'b0, ~op_be, 1'b0}; tag = "R5"; sel = 1'b1;
        end
        if (t == op_a + RD) ersp = 1'b1;
      end else if (op_kind == 3 && t == op_a) begin
        tag = "R8";
      end
      ap = {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe};
      chk(ap == ep, tag, 32'(ap), 32'(ep));
      chk(req_ready == (t >= busy_end), "R2 ready", 32'(req_ready), 32'(t >= busy_end));
      chk(rsp_valid == ersp, "R6 rsp_valid", 32'(rsp_valid), 32'(ersp));
      if (ersp) chk(rsp_data == exp_rdata, "R6 R9 rsp_data", 32'(rsp_data), 32'(exp_rdata));
      if (sel) chk(mem_addr == op_addr, "R3 R5 addr", 32'(mem_addr), 32'(op_addr));
      if (op_kind == 1 && mem_dq_oe)
        chk(mem_dq_out == op_wdata, "R3 dq_out", 32'(mem_dq_out), 32'(op_wdata));

      // R10 interval widths
      if (!mem_we_n) we_run++;
      else if (we_run > 0) begin chk(we_run == WP, "R10 we width", 32'(we_run), 32'(WP)); we_run = 0; end
      if (!mem_oe_n) oe_run++;
      else if (oe_run > 0) begin
        chk(oe_run == RD, "R10 oe width", 32'(oe_run), 32'(RD)); oe_run = 0; oe_rise_t = t;
      end
      // R7 gap between read release and data drive
      if (mem_dq_oe && !prev_dq_oe)
        chk(t - oe_rise_t >= TA, "R7 turnaround", 32'(t - oe_rise_t), 32'(TA));
      prev_dq_oe = mem_dq_oe;

      // behavioural RAM
      if (!mem_ce_n && mem_ce && !mem_we_n && mem_dq_oe) begin
        logic [15:0] w;
        w = rd_word(ram, int'(mem_addr));
        if (!mem_bs_n[0]) w[7:0]  = mem_dq_out[7:0];
        if (!mem_bs_n[1]) w[15:8] = mem_dq_out[15:8];
        ram[int'(mem_addr)] = w;
      end
      if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n) begin
        logic [15:0] r;
        r = rd_word(ram, int'(mem_addr));
        mem_dq_in = {mem_bs_n[1] ? 8'h00 : r[15:8], mem_bs_n[0] ? 8'h00 : r[7:0]};
      end else begin
        mem_dq_in = 16'h0000;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic wr, input logic [18:0] a, input logic [15:0] d, input logic [1:0] be);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=complete");
    report();
  end

  initial begin
    idle(3);
    // R1 reset state
    chk({mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe} == 7'b1011110,
        "R1 reset pins", 32'({mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe}), 32'h5E);
    chk(rsp_valid == 1'b0, "R1 reset rsp", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    idle(2);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);

    send(1, 19'h00010, 16'h1234, 2'b11); idle(20);
    send(0, 19'h00010, 16'h0000, 2'b11); idle(20);
    send(1, 19'h00010, 16'hABCD, 2'b01); idle(20);             // R9 lower only
    send(0, 19'h00010, 16'h0000, 2'b11); idle(20);
    send(1, 19'h00010, 16'h5678, 2'b10); idle(20);             // R9 upper only
    send(0, 19'h00010, 16'h0000, 2'b10); idle(20);             // R6 masked lane
    send(1, 19'h00010, 16'hFFFF, 2'b00); idle(5);              // R8 no-op
    send(0, 19'h00010, 16'h0000, 2'b11); idle(20);
    // R7 read then write held valid: accept falls on the response cycle
    send(0, 19'h7FFFF, 16'h0000, 2'b11);
    send(1, 19'h7FFFF, 16'hC0DE, 2'b11);
    send(0, 19'h7FFFF, 16'h0000, 2'b11);                       // write then read
    send(0, 19'h00010, 16'h0000, 2'b01);                       // read then read
    send(1, 19'h00020, 16'h0000, 2'b00);                       // R8 no-op in a burst
    send(1, 19'h00020, 16'h4455, 2'b11);
    idle(20);
    for (int i = 0; i < 40; i++) begin
      send(i[0], 19'(i % 5), 16'(i * 16'h1357), 2'(i % 4));
      if (i % 3 == 0) idle(i % 7);
    end
    idle(30);
    report();
  end

endmodule